// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block sits at the front of a variable-length instruction decoder. It takes the bytes of an instruction one at a time over a valid/ready input. Each byte that is a prefix is absorbed into a set of accumulated attributes. The first byte that is not a prefix is handed on as the opcode. It appears for one cycle on the opcode outputs, together with everything the prefixes said about that instruction.

The attributes it reports are:
- repeat-while-equal, which also serves as plain repeat;
- repeat-while-not-equal;
- bus lock;
- operand-size override;
- address-size override;
- a selected segment override;
- the number of prefix bytes consumed.

Prefixes may come in any order. When segment overrides conflict, or both repeat kinds appear, the later byte decides. At most `MAX_PFX` prefixes (default 4) are allowed. One more raises an error pulse, and the scanner then discards the rest of that instruction up to and including its opcode.

The block neither decodes the opcode nor checks whether a prefix is legal for it.

Top module: `prefix_scanner`

## Requirements
- R1: While reset is held and after its release, op_valid and pfx_err are low, in_ready is high, and all attribute outputs and pfx_count are zero.
- R2: The prefix bytes are recognised as follows, and each sets its flag in the attributes of the instruction it precedes:
  - F3 sets rep_eq;
  - F2 sets rep_ne;
  - F0 sets lock;
  - 66 sets opsz;
  - 67 sets adsz.
- R3: Four bytes are segment overrides: 26, 2E, 36 and 3E. Each sets seg_valid, with seg_sel = 00, 01, 10 and 11 respectively (byte bits 4:3). When several appear, the last one accepted is reported.
- R4: When both F2 and F3 appear, only the flag of the one accepted last is reported, so rep_eq and rep_ne are never high together.
- R5: The first non-prefix byte accepted raises op_valid in the next cycle, for exactly one cycle, with op_byte equal to that byte.
- R6: pfx_count reported with op_valid equals the number of prefix bytes accepted before the opcode (0 to MAX_PFX). Repeated prefixes are counted.
- R7: Accepting a prefix when MAX_PFX have already been taken raises pfx_err for one cycle in the next cycle. That instruction then produces no op_valid: later prefixes and its opcode byte are discarded.
- R8: In the cycle op_valid or pfx_err is high, in_ready is low. All accumulated state is cleared, so the next instruction starts with no flags, no segment and a count of zero.
- R9: A byte presented while in_valid is low has no effect on any output or on the next instruction's attributes.
- R10: Prefixes are accepted in any order and any mix. The flags reported are the union of those seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Scanner can accept a byte |
| op_valid | output | 1 | One-cycle pulse: opcode and attributes valid |
| op_byte | output | 8 | Opcode byte (first non-prefix byte) |
| rep_eq | output | 1 | Repeat / repeat-while-equal seen |
| rep_ne | output | 1 | Repeat-while-not-equal seen |
| lock | output | 1 | Lock prefix seen |
| opsz | output | 1 | Operand-size override seen |
| adsz | output | 1 | Address-size override seen |
| seg_valid | output | 1 | A segment override was given |
| seg_sel | output | 2 | Segment selected: 00 ES, 01 CS, 10 SS, 11 DS |
| pfx_count | output | $clog2(MAX_PFX+1) | Prefix bytes consumed by this instruction |
| pfx_err | output | 1 | One-cycle pulse: too many prefixes, instruction dropped |

## Verification
Every result comes out exactly one cycle after the byte that causes it is accepted:
- op_valid and the attributes follow the opcode byte;
- pfx_err follows the prefix that overflows the count.

The bench drives each byte just after a falling edge. Once in_ready is seen high, it waits for the following falling edge, where the effect of that rising-edge acceptance is already settled, and samples the outputs there. One more falling edge then confirms the pulse has dropped. The one-cycle input bubble after an opcode or an error is absorbed by the driving task, which waits on in_ready before presenting the next byte.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [2:0] {
    PK_NONE  = 3'd0,
    PK_REPE  = 3'd1,
    PK_REPNE = 3'd2,
    PK_LOCK  = 3'd3,
    PK_OPSZ  = 3'd4,
    PK_ADSZ  = 3'd5,
    PK_SEG   = 3'd6
  } pfx_kind_e;

  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_DROP = 1'b1
  } scan_st_e;

  // Map a byte to the kind of prefix it is (PK_NONE for an opcode byte).
  function automatic pfx_kind_e pfx_kind_of(input logic [7:0] b);
    pfx_kind_e k;
    case (b)
      8'hF3:                      k = PK_REPE;
      8'hF2:                      k = PK_REPNE;
      8'hF0:                      k = PK_LOCK;
      8'h66:                      k = PK_OPSZ;
      8'h67:                      k = PK_ADSZ;
      8'h26, 8'h2E, 8'h36, 8'h3E: k = PK_SEG;
      default:                    k = PK_NONE;
    endcase
    return k;
  endfunction

  // Segment overrides differ only in bits 4:3: 00 ES, 01 CS, 10 SS, 11 DS.
  function automatic logic [1:0] seg_code_of(input logic [7:0] b);
    return b[4:3];
  endfunction

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
(
  input  logic [7:0] byte_in,
  output logic       is_pfx,
  output pfx_kind_e  kind,
  output logic [1:0] seg_code
);

  always_comb begin
    kind     = pfx_kind_of(byte_in);
    is_pfx   = (kind != PK_NONE);
    seg_code = seg_code_of(byte_in);
  end

endmodule

// File: rtl/pfx_accum.sv
module pfx_accum
  import pfx_pkg::*;
#(
  parameter int MAX_PFX = 4,
  localparam int CW = $clog2(MAX_PFX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          clr,
  input  pfx_kind_e     kind,
  input  logic [1:0]    seg_code,
  output logic          a_rep_eq,
  output logic          a_rep_ne,
  output logic          a_lock,
  output logic          a_opsz,
  output logic          a_adsz,
  output logic          a_seg_v,
  output logic [1:0]    a_seg,
  output logic [CW-1:0] a_cnt,
  output logic          full
);

  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PFX);

  assign full = (a_cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      a_rep_eq <= 1'b0;
      a_rep_ne <= 1'b0;
      a_lock   <= 1'b0;
      a_opsz   <= 1'b0;
      a_adsz   <= 1'b0;
      a_seg_v  <= 1'b0;
      a_seg    <= 2'b00;
      a_cnt    <= '0;
    end else if (take) begin
      a_cnt <= a_cnt + CW'(1);
      case (kind)
        PK_REPE: begin
          a_rep_eq <= 1'b1;
          a_rep_ne <= 1'b0;
        end
        PK_REPNE: begin
          a_rep_ne <= 1'b1;
          a_rep_eq <= 1'b0;
        end
        PK_LOCK: a_lock <= 1'b1;
        PK_OPSZ: a_opsz <= 1'b1;
        PK_ADSZ: a_adsz <= 1'b1;
        PK_SEG: begin
          a_seg_v <= 1'b1;
          a_seg   <= seg_code;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pfx_ctrl.sv
module pfx_ctrl
  import pfx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic is_pfx,
  input  logic full,
  output logic in_ready,
  output logic fire,
  output logic pfx_take,
  output logic opc_take,
  output logic overflow_hit,
  output logic clr,
  output logic opv_q,
  output logic err_q
);

  scan_st_e st_q;
  logic     drop_end;

  always_comb begin
    in_ready     = !(opv_q || err_q);
    fire         = in_valid && in_ready;
    pfx_take     = fire && (st_q == ST_SCAN) && is_pfx && !full;
    overflow_hit = fire && (st_q == ST_SCAN) && is_pfx && full;
    opc_take     = fire && (st_q == ST_SCAN) && !is_pfx;
    drop_end     = fire && (st_q == ST_DROP) && !is_pfx;
    clr          = opc_take || overflow_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_SCAN;
      opv_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      opv_q <= opc_take;
      err_q <= overflow_hit;
      if (overflow_hit)  st_q <= ST_DROP;
      else if (drop_end) st_q <= ST_SCAN;
    end
  end

endmodule

// File: rtl/prefix_scanner.sv
module prefix_scanner
  import pfx_pkg::*;
#(
  parameter int MAX_PFX = 4,
  localparam int CW = $clog2(MAX_PFX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic          in_ready,
  output logic          op_valid,
  output logic [7:0]    op_byte,
  output logic          rep_eq,
  output logic          rep_ne,
  output logic          lock,
  output logic          opsz,
  output logic          adsz,
  output logic          seg_valid,
  output logic [1:0]    seg_sel,
  output logic [CW-1:0] pfx_count,
  output logic          pfx_err
);

  // Named internal events, observed by the bound checker.
  logic          is_pfx;
  pfx_kind_e     kind;
  logic [1:0]    seg_code;
  logic          fire, pfx_take, opc_take, overflow_hit, clr, full;
  logic          a_rep_eq, a_rep_ne, a_lock, a_opsz, a_adsz, a_seg_v;
  logic [1:0]    a_seg;
  logic [CW-1:0] a_cnt;

  pfx_classify u_cls (
    .byte_in  (in_byte),
    .is_pfx   (is_pfx),
    .kind     (kind),
    .seg_code (seg_code)
  );

  pfx_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .is_pfx       (is_pfx),
    .full         (full),
    .in_ready     (in_ready),
    .fire         (fire),
    .pfx_take     (pfx_take),
    .opc_take     (opc_take),
    .overflow_hit (overflow_hit),
    .clr          (clr),
    .opv_q        (op_valid),
    .err_q        (pfx_err)
  );

  pfx_accum #(.MAX_PFX(MAX_PFX)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (pfx_take),
    .clr      (clr),
    .kind     (kind),
    .seg_code (seg_code),
    .a_rep_eq (a_rep_eq),
    .a_rep_ne (a_rep_ne),
    .a_lock   (a_lock),
    .a_opsz   (a_opsz),
    .a_adsz   (a_adsz),
    .a_seg_v  (a_seg_v),
    .a_seg    (a_seg),
    .a_cnt    (a_cnt),
    .full     (full)
  );

  // Output stage: snapshot the accumulated attributes with the opcode.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_byte   <= 8'h00;
      rep_eq    <= 1'b0;
      rep_ne    <= 1'b0;
      lock      <= 1'b0;
      opsz      <= 1'b0;
      adsz      <= 1'b0;
      seg_valid <= 1'b0;
      seg_sel   <= 2'b00;
      pfx_count <= '0;
    end else if (opc_take) begin
      op_byte   <= in_byte;
      rep_eq    <= a_rep_eq;
      rep_ne    <= a_rep_ne;
      lock      <= a_lock;
      opsz      <= a_opsz;
      adsz      <= a_adsz;
      seg_valid <= a_seg_v;
      seg_sel   <= a_seg;
      pfx_count <= a_cnt;
    end
  end

endmodule

// File: rtl/pfx_scanner_chk.sv
module pfx_scanner_chk #(
  parameter int MAX_PFX = 4,
  localparam int CW = $clog2(MAX_PFX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          op_valid,
  input logic          rep_eq,
  input logic          rep_ne,
  input logic [CW-1:0] pfx_count,
  input logic          pfx_err,
  input logic          opc_take,
  input logic          overflow_hit
);

  AST_OPV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid); // R5

  AST_OPV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(opc_take)); // R5

  AST_READY_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid || pfx_err) |-> !in_ready); // R8

  AST_REP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !(rep_eq && rep_ne)); // R4

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (pfx_count <= CW'(MAX_PFX))); // R6

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_err |-> $past(overflow_hit)); // R7

  AST_ERR_NO_OPV: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_err |-> !op_valid); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!op_valid && !pfx_err)); // R9

endmodule

bind prefix_scanner pfx_scanner_chk #(.MAX_PFX(MAX_PFX)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .op_valid     (op_valid),
  .rep_eq       (rep_eq),
  .rep_ne       (rep_ne),
  .pfx_count    (pfx_count),
  .pfx_err      (pfx_err),
  .opc_take     (opc_take),
  .overflow_hit (overflow_hit)
);

// File: tb/tb_prefix_scanner.sv
module tb_prefix_scanner;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_PFX    = 4;
  localparam int CW         = $clog2(MAX_PFX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = 8'h00;
  logic          in_ready, op_valid, rep_eq, rep_ne, lock, opsz, adsz;
  logic          seg_valid, pfx_err;
  logic [7:0]    op_byte;
  logic [1:0]    seg_sel;
  logic [CW-1:0] pfx_count;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefix_scanner #(.MAX_PFX(MAX_PFX)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .op_valid(op_valid), .op_byte(op_byte),
    .rep_eq(rep_eq), .rep_ne(rep_ne), .lock(lock), .opsz(opsz), .adsz(adsz),
    .seg_valid(seg_valid), .seg_sel(seg_sel), .pfx_count(pfx_count),
    .pfx_err(pfx_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; returns at the falling edge after acceptance.
  task automatic send(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'hF0;
  endtask

  // Expected attribute vector: {op_byte, rep_eq, rep_ne, lock, opsz, adsz, seg_valid, seg_sel, count}
  function automatic logic [31:0] pack(input logic [7:0] ob, input bit re, input bit rn,
      input bit lk, input bit os, input bit as, input bit sv, input logic [1:0] sg,
      input int cnt);
    return {11'd0, ob, re, rn, lk, os, as, sv, sg, 5'(cnt)};
  endfunction

  task automatic expect_op(input string tag, input logic [31:0] exp);
    logic [31:0] act;
    act = pack(op_byte, rep_eq, rep_ne, lock, opsz, adsz, seg_valid, seg_sel, int'(pfx_count));
    chk(op_valid === 1'b1, {tag, " R5 op_valid"}, 32'(op_valid), 32'd1);
    chk(act === exp, {tag, " attributes"}, act, exp);
    chk(in_ready === 1'b0, {tag, " R8 ready bubble"}, 32'(in_ready), 32'd0);
    @(negedge clk);
    chk(op_valid === 1'b0, {tag, " R5 single pulse"}, 32'(op_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk(op_valid === 1'b0 && pfx_err === 1'b0, "R1 pulses idle", {op_valid, pfx_err}, 0);
    chk(in_ready === 1'b1, "R1 ready", 32'(in_ready), 32'd1);
    chk(pack(op_byte, rep_eq, rep_ne, lock, opsz, adsz, seg_valid, seg_sel,
             int'(pfx_count)) === 32'd0, "R1 outputs zero",
        pack(op_byte, rep_eq, rep_ne, lock, opsz, adsz, seg_valid, seg_sel,
             int'(pfx_count)), 0);
  endtask

  task automatic t_each_flag();
    send(8'hF3); send(8'h8B); expect_op("R2 F3", pack(8'h8B,1,0,0,0,0,0,2'b00,1));
    send(8'hF2); send(8'hA4); expect_op("R2 F2", pack(8'hA4,0,1,0,0,0,0,2'b00,1));
    send(8'hF0); send(8'h01); expect_op("R2 F0", pack(8'h01,0,0,1,0,0,0,2'b00,1));
    send(8'h66); send(8'h89); expect_op("R2 66", pack(8'h89,0,0,0,1,0,0,2'b00,1));
    send(8'h67); send(8'hC7); expect_op("R2 67", pack(8'hC7,0,0,0,0,1,0,2'b00,1));
  endtask

  task automatic t_segments();
    send(8'h26); send(8'h90); expect_op("R3 ES", pack(8'h90,0,0,0,0,0,1,2'b00,1));
    send(8'h2E); send(8'h90); expect_op("R3 CS", pack(8'h90,0,0,0,0,0,1,2'b01,1));
    send(8'h36); send(8'h90); expect_op("R3 SS", pack(8'h90,0,0,0,0,0,1,2'b10,1));
    send(8'h3E); send(8'h90); expect_op("R3 DS", pack(8'h90,0,0,0,0,0,1,2'b11,1));
    send(8'h2E); send(8'h36); send(8'h26); send(8'h8F);
    expect_op("R3 last seg wins", pack(8'h8F,0,0,0,0,0,1,2'b00,3));
  endtask

  task automatic t_rep_last();
    send(8'hF3); send(8'hF2); send(8'hA6);
    expect_op("R4 F3 then F2", pack(8'hA6,0,1,0,0,0,0,2'b00,2));
    send(8'hF2); send(8'hF3); send(8'hA6);
    expect_op("R4 F2 then F3", pack(8'hA6,1,0,0,0,0,0,2'b00,2));
  endtask

  task automatic t_mix_count();
    send(8'h8B); expect_op("R6 no prefix", pack(8'h8B,0,0,0,0,0,0,2'b00,0));
    send(8'h67); send(8'hF0); send(8'h3E); send(8'h66); send(8'h03);
    expect_op("R10 R6 mix of four", pack(8'h03,0,0,1,1,1,1,2'b11,4));
    send(8'h66); send(8'h66); send(8'h58);
    expect_op("R6 repeated prefix", pack(8'h58,0,0,0,1,0,0,2'b00,2));
  endtask

  task automatic t_overflow();
    int seen_op;
    seen_op = 0;
    send(8'hF0); send(8'h66); send(8'h67); send(8'h2E);
    send(8'hF3);
    chk(pfx_err === 1'b1, "R7 err on fifth prefix", 32'(pfx_err), 32'd1);
    chk(in_ready === 1'b0, "R8 ready bubble on err", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk(pfx_err === 1'b0, "R7 err single pulse", 32'(pfx_err), 32'd0);
    send(8'h66); seen_op += int'(op_valid);
    send(8'h90); seen_op += int'(op_valid);
    @(negedge clk); seen_op += int'(op_valid);
    chk(seen_op == 0, "R7 dropped instruction gives no opcode", seen_op, 0);
    send(8'h8B);
    expect_op("R8 R7 clean after drop", pack(8'h8B,0,0,0,0,0,0,2'b00,0));
  endtask

  task automatic t_idle_ignored();
    send(8'hF0); send(8'h26); send(8'h90);
    expect_op("R8 setup", pack(8'h90,0,0,1,0,0,1,2'b00,2));
    in_byte = 8'hF3;
    repeat (3) @(negedge clk);
    in_byte = 8'h8B;
    @(negedge clk);
    chk(op_valid === 1'b0, "R9 byte without valid ignored", 32'(op_valid), 32'd0);
    send(8'hC3);
    expect_op("R9 R8 cleared state", pack(8'hC3,0,0,0,0,0,0,2'b00,0));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_each_flag();
    t_segments();
    t_rep_last();
    t_mix_count();
    t_overflow();
    t_idle_ignored();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
    end
  end

endmodule